// File: doc/BRIEF.md
# Power-Up Self-Test Sequencer

After reset this block runs a fixed chain of hardware checks on the resources around it. It shows its progress on one LED. First comes a short flicker that does not count. Then the LED gives one flash for every stage that passes. Five stages run in a fixed order:

- the 128-byte scratch RAM;
- two general register banks;
- the sound generator's registers;
- a handshake check on the speech buffer.

The four storage stages use a counting march. Every byte receives every 8-bit value in ascending order, and each value is read back before the next is written. The speech stage pushes nine bytes into the buffer. After each of the first eight it expects a buffer-low interrupt. After the ninth it expects silence.

All four storage stages share one register port. A 2-bit target select picks the RAM, bank A, bank B or the sound registers. The speech bytes leave on a valid/ready stream. The sequencer holds `spk_valid` and `spk_data` steady until `spk_ready` is seen high at a clock edge, so the receiver may stall for any number of cycles. The first failure halts the sequencer. It then reports the number of the failing stage and keeps the LED dark. A clean run ends with `done`, which tells the surroundings that the resources are released for normal operation.

Top module: `selftest_seq`

## Requirements
- R1: After reset release the LED toggles for FLICK_CYC cycles at one change every FLICK_TOG cycles and ends low. This flicker is not a stage flash. No register access and no stream transfer happen during it.
- R2: The RAM stage uses target select 0. It walks the addresses 0 to RAM_WORDS-1 in ascending order. At each address it writes the values 0x00 to 0xFF in ascending order. Each write cycle is followed at once by a read cycle at the same address. The read data, valid one cycle after the read strobe, must equal the value written.
- R3: The later storage stages use the same pattern as R2. Target select 1 covers bank A (BANK_WORDS deep), select 2 covers bank B (BANK_WORDS deep) and select 3 covers the sound registers (SND_WORDS deep), in that order.
- R4: Every stage that passes gives exactly one flash. The LED is high for FLASH_ON cycles and then low for FLASH_OFF cycles. Only after that does the next stage begin.
- R5: The speech stage sends the byte values 0 to 8 in order on the stream. While `spk_ready` is low, `spk_valid` stays high and `spk_data` stays unchanged.
- R6: After each of the first eight accepted bytes, `bl_irq` must be seen high within IRQ_WAIT cycles. Otherwise the stage fails.
- R7: After the ninth accepted byte the sequencer watches for IRQ_WAIT cycles. Any high `bl_irq` in that window fails the stage; a quiet window passes it.
- R8: On a failure the sequencer stops for good, until the next reset. It drives `fail` high and holds the LED low. It keeps `err_code` at the failing stage: 1 for RAM, 2 for bank A, 3 for bank B, 4 for the sound registers and 5 for speech. After that it drives no register access and no stream transfer.
- R9: After the fifth flash, `done` goes high and stays high. At the same time `err_code` is 0, `fail` is low and the port stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mem_sel | output | 2 | Target select: 0 RAM, 1 bank A, 2 bank B, 3 sound registers |
| mem_addr | output | AW | Register address within the selected target |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe; data is returned one cycle later |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data from the selected target |
| spk_valid | output | 1 | Speech byte valid |
| spk_ready | input | 1 | Speech buffer accepts the byte |
| spk_data | output | DATA_W | Speech byte |
| bl_irq | input | 1 | Buffer-low interrupt from the speech buffer |
| led | output | 1 | Status LED |
| fail | output | 1 | A stage failed; sequencer halted |
| err_code | output | 3 | Failing stage number, 0 while none failed |
| done | output | 1 | All stages passed; resources released |

## Verification
The hardest cases to reach are the speech-stage failures. In one, an interrupt goes missing partway through the fill. In the other, an interrupt arrives after the ninth byte. Both sit behind four full storage marches, so the memory model never corrupts data in these runs. The buffer model counts accepted bytes and answers each one with a delayed interrupt pulse. It can drop the pulse for the fourth byte or add one after the ninth, while its ready line stalls one cycle in three.

// File: rtl/selftest_pkg.sv
package selftest_pkg;

  typedef enum logic [2:0] {
    PH_FLICK,
    PH_MARCH,
    PH_SPEECH,
    PH_FLASH,
    PH_FAIL,
    PH_DONE
  } phase_t;

  localparam logic [2:0] STG_FIRST  = 3'd1;
  localparam logic [2:0] STG_SPEECH = 3'd5;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/st_led_timer.sv
module st_led_timer #(
  parameter int unsigned FLICK_CYC = 40,
  parameter int unsigned FLICK_TOG = 6,
  parameter int unsigned FLASH_ON  = 10,
  parameter int unsigned FLASH_OFF = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flash_go,
  output logic led,
  output logic flick_done,
  output logic flash_done
);
  localparam int unsigned MAXC = selftest_pkg::max3(FLICK_CYC, FLASH_ON, FLASH_OFF);
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam int unsigned TW   = $clog2(FLICK_TOG + 1);

  typedef enum logic [1:0] {T_FLICK, T_IDLE, T_ON, T_OFF} tstate_t;

  tstate_t        st;
  logic [CW-1:0]  cnt;
  logic [TW-1:0]  tcnt;
  logic           blink;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= T_FLICK;
      cnt        <= '0;
      tcnt       <= '0;
      blink      <= 1'b0;
      flash_done <= 1'b0;
    end else begin
      flash_done <= 1'b0;
      case (st)
        T_FLICK: begin
          if (cnt == CW'(FLICK_CYC - 1)) begin
            st    <= T_IDLE;
            cnt   <= '0;
            blink <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
            if (tcnt == TW'(FLICK_TOG - 1)) begin
              tcnt  <= '0;
              blink <= ~blink;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        T_IDLE: begin
          if (flash_go) begin
            st  <= T_ON;
            cnt <= '0;
          end
        end
        T_ON: begin
          if (cnt == CW'(FLASH_ON - 1)) begin
            st  <= T_OFF;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == CW'(FLASH_OFF - 1)) begin
            st         <= T_IDLE;
            cnt        <= '0;
            flash_done <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign led        = ((st == T_FLICK) && blink) || (st == T_ON);
  assign flick_done = (st != T_FLICK);

endmodule

// File: rtl/st_march.sv
module st_march #(
  parameter int unsigned DW         = 8,
  parameter int unsigned AW         = 7,
  parameter int unsigned RAM_WORDS  = 128,
  parameter int unsigned BANK_WORDS = 16,
  parameter int unsigned SND_WORDS  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [1:0]    sel_in,
  output logic [1:0]    mem_sel,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          pass,
  output logic          fault
);
  typedef enum logic [1:0] {M_IDLE, M_WR, M_RD, M_CMP} mstate_t;

  mstate_t        st;
  logic [1:0]     sel_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  val_q;
  logic [AW-1:0]  last_addr;

  always_comb begin
    case (sel_q)
      2'd0:    last_addr = AW'(RAM_WORDS - 1);
      2'd3:    last_addr = AW'(SND_WORDS - 1);
      default: last_addr = AW'(BANK_WORDS - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= M_IDLE;
      sel_q  <= '0;
      addr_q <= '0;
      val_q  <= '0;
      pass   <= 1'b0;
      fault  <= 1'b0;
    end else begin
      pass  <= 1'b0;
      fault <= 1'b0;
      case (st)
        M_IDLE: begin
          if (go) begin
            st     <= M_WR;
            sel_q  <= sel_in;
            addr_q <= '0;
            val_q  <= '0;
          end
        end
        M_WR: st <= M_RD;
        M_RD: st <= M_CMP;
        default: begin
          if (mem_rdata != val_q) begin
            fault <= 1'b1;
            st    <= M_IDLE;
          end else if (val_q == '1) begin
            val_q <= '0;
            if (addr_q == last_addr) begin
              pass <= 1'b1;
              st   <= M_IDLE;
            end else begin
              addr_q <= addr_q + 1'b1;
              st     <= M_WR;
            end
          end else begin
            val_q <= val_q + 1'b1;
            st    <= M_WR;
          end
        end
      endcase
    end
  end

  assign mem_sel   = sel_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = val_q;
  assign mem_we    = (st == M_WR);
  assign mem_re    = (st == M_RD);

endmodule

// File: rtl/st_speech_chk.sv
module st_speech_chk #(
  parameter int unsigned DW       = 8,
  parameter int unsigned N_LOW    = 8,
  parameter int unsigned IRQ_WAIT = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  output logic          s_valid,
  input  logic          s_ready,
  output logic [DW-1:0] s_data,
  input  logic          bl_irq,
  output logic          pass,
  output logic          fault
);
  localparam int unsigned IW = $clog2(N_LOW + 2);
  localparam int unsigned CW = $clog2(IRQ_WAIT + 1);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_QUIET} sstate_t;

  sstate_t       st;
  logic [IW-1:0] idx;
  logic [CW-1:0] tcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      idx   <= '0;
      tcnt  <= '0;
      pass  <= 1'b0;
      fault <= 1'b0;
    end else begin
      pass  <= 1'b0;
      fault <= 1'b0;
      case (st)
        S_IDLE: begin
          if (go) begin
            st  <= S_SEND;
            idx <= '0;
          end
        end
        S_SEND: begin
          if (s_ready) begin
            idx  <= idx + 1'b1;
            tcnt <= '0;
            st   <= (idx == IW'(N_LOW)) ? S_QUIET : S_WAIT;
          end
        end
        S_WAIT: begin
          if (bl_irq) begin
            st <= S_SEND;
          end else if (tcnt == CW'(IRQ_WAIT - 1)) begin
            fault <= 1'b1;
            st    <= S_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: begin
          if (bl_irq) begin
            fault <= 1'b1;
            st    <= S_IDLE;
          end else if (tcnt == CW'(IRQ_WAIT - 1)) begin
            pass <= 1'b1;
            st   <= S_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign s_valid = (st == S_SEND);
  assign s_data  = DW'(idx);

endmodule

// File: rtl/selftest_seq.sv
module selftest_seq #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned RAM_WORDS  = 128,
  parameter int unsigned BANK_WORDS = 16,
  parameter int unsigned SND_WORDS  = 16,
  parameter int unsigned FLICK_CYC  = 3_000_000,
  parameter int unsigned FLICK_TOG  = 250_000,
  parameter int unsigned FLASH_ON   = 2_000_000,
  parameter int unsigned FLASH_OFF  = 2_000_000,
  parameter int unsigned N_LOW      = 8,
  parameter int unsigned IRQ_WAIT   = 10_000,
  localparam int unsigned MAXW      = selftest_pkg::max3(RAM_WORDS, BANK_WORDS, SND_WORDS),
  localparam int unsigned AW        = (MAXW > 1) ? $clog2(MAXW) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [1:0]        mem_sel,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              spk_valid,
  input  logic              spk_ready,
  output logic [DATA_W-1:0] spk_data,
  input  logic              bl_irq,
  output logic              led,
  output logic              fail,
  output logic [2:0]        err_code,
  output logic              done
);
  import selftest_pkg::*;

  phase_t     phase;
  logic [2:0] stage;
  logic [2:0] err_q;
  logic       flash_go, march_go, speech_go;
  logic       flick_done, flash_done;
  logic       m_pass, m_fault, s_pass, s_fault;
  logic [1:0] sel_next;

  assign sel_next = stage[1:0] - 2'd1;

  st_led_timer #(
    .FLICK_CYC(FLICK_CYC), .FLICK_TOG(FLICK_TOG),
    .FLASH_ON(FLASH_ON),   .FLASH_OFF(FLASH_OFF)
  ) u_led (
    .clk(clk), .rst_n(rst_n), .flash_go(flash_go),
    .led(led), .flick_done(flick_done), .flash_done(flash_done)
  );

  st_march #(
    .DW(DATA_W), .AW(AW), .RAM_WORDS(RAM_WORDS),
    .BANK_WORDS(BANK_WORDS), .SND_WORDS(SND_WORDS)
  ) u_march (
    .clk(clk), .rst_n(rst_n), .go(march_go), .sel_in(sel_next),
    .mem_sel(mem_sel), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pass(m_pass), .fault(m_fault)
  );

  st_speech_chk #(
    .DW(DATA_W), .N_LOW(N_LOW), .IRQ_WAIT(IRQ_WAIT)
  ) u_speech (
    .clk(clk), .rst_n(rst_n), .go(speech_go),
    .s_valid(spk_valid), .s_ready(spk_ready), .s_data(spk_data),
    .bl_irq(bl_irq), .pass(s_pass), .fault(s_fault)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_FLICK;
      stage     <= STG_FIRST;
      err_q     <= '0;
      flash_go  <= 1'b0;
      march_go  <= 1'b0;
      speech_go <= 1'b0;
    end else begin
      flash_go  <= 1'b0;
      march_go  <= 1'b0;
      speech_go <= 1'b0;
      case (phase)
        PH_FLICK: begin
          if (flick_done) begin
            phase    <= PH_MARCH;
            march_go <= 1'b1;
          end
        end
        PH_MARCH: begin
          if (m_fault) begin
            phase <= PH_FAIL;
            err_q <= stage;
          end else if (m_pass) begin
            phase    <= PH_FLASH;
            flash_go <= 1'b1;
          end
        end
        PH_SPEECH: begin
          if (s_fault) begin
            phase <= PH_FAIL;
            err_q <= stage;
          end else if (s_pass) begin
            phase    <= PH_FLASH;
            flash_go <= 1'b1;
          end
        end
        PH_FLASH: begin
          if (flash_done) begin
            if (stage == STG_SPEECH) begin
              phase <= PH_DONE;
            end else begin
              stage <= stage + 3'd1;
              if (stage + 3'd1 == STG_SPEECH) begin
                phase     <= PH_SPEECH;
                speech_go <= 1'b1;
              end else begin
                phase    <= PH_MARCH;
                march_go <= 1'b1;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign fail     = (phase == PH_FAIL);
  assign done     = (phase == PH_DONE);
  assign err_code = err_q;

endmodule

// File: rtl/selftest_seq_chk.sv
module selftest_seq_chk #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mem_sel,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          mem_re,
  input logic          spk_valid,
  input logic          spk_ready,
  input logic [DW-1:0] spk_data,
  input logic          led,
  input logic          fail,
  input logic [2:0]    err_code,
  input logic          done
);

  a_r2_read_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> mem_re && $stable(mem_addr) && $stable(mem_sel));

  a_r2_single_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  a_r5_stream_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (spk_valid && !spk_ready) |=> spk_valid && $stable(spk_data));

  a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> fail && $stable(err_code));

  a_r8_led_dark: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !led);

  a_r8_code_set: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (err_code != 3'd0) && (err_code <= 3'd5));

  a_r8_halted_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (fail || done) |-> !(mem_we || mem_re || spk_valid));

  a_r9_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err_code == 3'd0) && !fail && !led);

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

endmodule

bind selftest_seq selftest_seq_chk #(.AW(AW), .DW(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_sel(mem_sel), .mem_addr(mem_addr),
  .mem_we(mem_we), .mem_re(mem_re), .spk_valid(spk_valid),
  .spk_ready(spk_ready), .spk_data(spk_data), .led(led), .fail(fail),
  .err_code(err_code), .done(done)
);

// File: tb/test_selftest_seq.sv
module test_selftest_seq;
  localparam int CLK_PERIOD = 10;
  localparam int RAMW = 4, BANKW = 2, SNDW = 2;
  localparam int FLK = 40, TOG = 6, FON = 10, FOFF = 10, IRQW = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mem_sel;
  logic [1:0] mem_addr;
  logic       mem_we, mem_re;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'h00;
  logic       spk_valid;
  logic       spk_ready = 1'b0;
  logic [7:0] spk_data;
  logic       bl_irq = 1'b0;
  logic       led, fail, done;
  logic [2:0] err_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  selftest_seq #(
    .DATA_W(8), .RAM_WORDS(RAMW), .BANK_WORDS(BANKW), .SND_WORDS(SNDW),
    .FLICK_CYC(FLK), .FLICK_TOG(TOG), .FLASH_ON(FON), .FLASH_OFF(FOFF),
    .N_LOW(8), .IRQ_WAIT(IRQW)
  ) i_selftest_seq (
    .clk(clk), .rst_n(rst_n), .mem_sel(mem_sel), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .spk_valid(spk_valid), .spk_ready(spk_ready), .spk_data(spk_data),
    .bl_irq(bl_irq), .led(led), .fail(fail), .err_code(err_code), .done(done)
  );

  int n_chk = 0, n_fail = 0;

  // fault configuration of the models
  int flt_on = 0, flt_sel = 0, flt_addr = 0, miss_idx = 0, extra_irq = 0;

  // register targets model: registered read, optional stuck-at-one on bit 7
  logic [7:0] mem [0:3][0:3];
  always @(posedge clk) begin
    if (mem_we) mem[mem_sel][mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_sel][mem_addr] |
      ((flt_on != 0 && int'(mem_sel) == flt_sel && int'(mem_addr) == flt_addr) ? 8'h80 : 8'h00);
  end

  // scoreboard queues and monitor counters
  int flash_q[$];
  int spk_q[$];
  int cyc, flick_edges, flick_busy, flashes, flash_bad, on_run, on_bad;
  int wr_bad, total_wr, spk_bad, last_act, nacc, pend, rcnt;
  int ex_sel, ex_addr, ex_val;
  int wcnt[0:3];
  bit hs_flag, led_prev;

  function automatic int depth_of(int s);
    return (s == 0) ? RAMW : (s == 3) ? SNDW : BANKW;
  endfunction

  // monitor, sampling mid-cycle
  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; flick_edges = 0; flick_busy = 0; flashes = 0; flash_bad = 0;
      on_run = 0; on_bad = 0; wr_bad = 0; total_wr = 0; spk_bad = 0;
      last_act = -1; ex_sel = 0; ex_addr = 0; ex_val = 0; led_prev = 1'b0;
      hs_flag = 1'b0;
      for (int i = 0; i < 4; i++) wcnt[i] = 0;
    end else begin
      cyc++;
      if (cyc <= FLK) begin
        if (led && !led_prev) flick_edges++;
        if (mem_we || mem_re || spk_valid) flick_busy++;
      end else begin
        if (led && !led_prev) begin
          flashes++;
          if (flash_q.size() == 0) flash_bad++;
          else if (flash_q.pop_front() != last_act) flash_bad++;
        end
        if (led) on_run++;
        else if (led_prev) begin
          if (on_run != FON) on_bad++;
          on_run = 0;
        end
      end
      led_prev = led;
      if (mem_we) begin
        if (int'(mem_sel) != ex_sel || int'(mem_addr) != ex_addr || int'(mem_wdata) != ex_val)
          wr_bad++;
        if (ex_val == 255) begin
          ex_val = 0;
          if (ex_addr == depth_of(ex_sel) - 1) begin ex_addr = 0; ex_sel++; end
          else ex_addr++;
        end else ex_val++;
        last_act = int'(mem_sel);
        total_wr++;
        if (mem_sel == 2'd0) wcnt[mem_addr]++;
      end
      if (spk_valid && spk_ready) begin
        hs_flag = 1'b1;
        last_act = 4;
        if (spk_q.size() == 0) spk_bad++;
        else if (spk_q.pop_front() != int'(spk_data)) spk_bad++;
      end
    end
  end

  // speech buffer model: stalls one cycle in three, answers bytes with a delayed pulse
  always @(posedge clk) begin
    #1;
    rcnt++;
    spk_ready = ((rcnt % 3) != 2);
    bl_irq = 1'b0;
    if (!rst_n) begin
      nacc = 0; pend = 0;
    end else if (hs_flag) begin
      hs_flag = 1'b0;
      nacc++;
      if ((nacc <= 8 && nacc != miss_idx) || (nacc == 9 && extra_irq != 0)) pend = 3;
    end else if (pend > 0) begin
      pend--;
      if (pend == 0) bl_irq = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int fs, input int fa, input int fo, input int mi, input int ex,
                          input int exp_fl, input int exp_err, input int exp_done,
                          input int exp_bytes);
    rst_n = 1'b0;
    flt_sel = fs; flt_addr = fa; flt_on = fo; miss_idx = mi; extra_irq = ex;
    flash_q.delete();
    spk_q.delete();
    for (int i = 0; i < exp_fl; i++) flash_q.push_back(i);
    for (int i = 0; i < exp_bytes; i++) spk_q.push_back(i);
    repeat (3) @(negedge clk);
    chk(!led && !fail && !done && err_code == 3'd0 && !mem_we && !mem_re && !spk_valid,
        "R8 reset state idle", int'(err_code), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 20000 && !(done || fail); i++) @(negedge clk);
    repeat (60) @(negedge clk);
    chk(flick_edges > 0, "R1 flicker toggles", flick_edges, 1);
    chk(flick_busy == 0, "R1 quiet during flicker", flick_busy, 0);
    chk(flashes == exp_fl, "R4 flash count", flashes, exp_fl);
    chk(flash_bad == 0, "R4 flash order", flash_bad, 0);
    chk(on_bad == 0, "R4 flash on-time", on_bad, 0);
    chk(wr_bad == 0, "R3 write order R2", wr_bad, 0);
    chk(spk_bad == 0 && spk_q.size() == 0, "R5 speech bytes", spk_bad + spk_q.size(), 0);
    chk(int'(err_code) == exp_err, "R8 err_code", int'(err_code), exp_err);
    chk(int'(fail) == ((exp_err != 0) ? 1 : 0), "R8 fail flag", int'(fail), (exp_err != 0) ? 1 : 0);
    chk(int'(done) == exp_done, "R9 done flag", int'(done), exp_done);
    chk(!led, "R8 led dark at end", int'(led), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    // clean run: all five stages pass
    run_case(0, 0, 0, 0, 0, 5, 0, 1, 9);
    chk(total_wr == 256 * (RAMW + 2 * BANKW + SNDW), "R3 march length", total_wr,
        256 * (RAMW + 2 * BANKW + SNDW));
    for (int a = 0; a < RAMW; a++) chk(wcnt[a] == 256, "R2 every value per byte", wcnt[a], 256);
    // RAM fault at address 2: stops after 2*256+1 writes, no flash
    run_case(0, 2, 1, 0, 0, 0, 1, 0, 0);
    chk(total_wr == 513, "R2 stop on first miscompare", total_wr, 513);
    // bank A fault
    run_case(1, 1, 1, 0, 0, 1, 2, 0, 0);
    // bank B fault
    run_case(2, 0, 1, 0, 0, 2, 3, 0, 0);
    // sound register fault
    run_case(3, 0, 1, 0, 0, 3, 4, 0, 0);
    // R6: interrupt missing after the fourth byte
    run_case(0, 0, 0, 4, 0, 4, 5, 0, 4);
    // R7: interrupt after the ninth byte
    run_case(0, 0, 0, 0, 1, 4, 5, 0, 9);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule